// File: doc/BRIEF.md
# Digital Power-On Clock Gating Controller

This controller decides when the digital section of a front-end chip has its clocks and its differential receivers running. Two sources may ask for power. The data-acquisition system asks for it across acquisition and conversion. The chip asks for it on its own while it reads out its data. The readout request starts with a start-readout pulse from the previous chip in the chain and ends when this chip's readout is done. The block keeps power on while either request is held.

A request turns on asynchronously. The receivers start at once, without waiting for a clock edge. The clock enables are delayed through a short synchronizer so that the gated clocks start cleanly. A request turns off synchronously on the slow clock. Once both requests are gone, the receiver enables and the clock enables fall together on one edge, no more than two ticks after the request input dropped. Each enable is built as a number of identical copies so that separate parts of the chip can be driven. The internal start pulse that launches the readout sequencer is held back until the clocks are running.

Top module: `dig_power_gate`

## Requirements
- R1: With `rst` held and all request inputs low, after the first edge `pwr_on`, every `lvds_en` bit, every `clk_en` bit and `ro_go` are 0.
- R2: A rise of `daq_on` drives every `lvds_en` bit to 1 before the next rising clock edge. The request stays latched even if `daq_on` falls again before that edge.
- R3: With the default `SYNC_STAGES` = 2, a request asserted between two edges sets every `clk_en` bit on the second rising edge after it, and not earlier.
- R4: `pwr_on` is 1 while the acquisition request or the readout request is latched, and is 0 when neither is latched.
- R5: If the last held request input is released before edge E0, `pwr_on` falls at E0, and every `lvds_en` and `clk_en` bit falls at the following edge E1.
- R6: All copies of `lvds_en` carry the same value, and so do all copies of `clk_en`. `clk_en` is nonzero only while `lvds_en` is all ones.
- R7: A pulse on `ro_start` latches the readout request at once. The request is held after the pulse ends and until `ro_done`.
- R8: `ro_done` high at a rising edge clears the readout request at that edge. An acquisition request that is still held keeps `pwr_on` and all enables at 1.
- R9: `ro_go` is a pulse one cycle wide. It is high only while `clk_en` is all ones, and it rises one edge after `clk_en` becomes all ones for a readout request that started with the clocks off.
- R10: `ro_go` fires once for each readout request. If the clocks are already running when `ro_start` arrives, `ro_go` is 1 after the first edge that follows the pulse.
- R11: `rst` high at a rising edge, with all request inputs low, clears both requests and all enables at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| daq_on | input | 1 | Acquisition power request; rise sets it asynchronously, low releases it |
| ro_start | input | 1 | Start-readout pulse from the previous chip; sets the readout request asynchronously |
| ro_done | input | 1 | End of this chip's readout; clears the readout request |
| pwr_on | output | 1 | Internal power-on, the OR of the latched requests |
| lvds_en | output | N_LVDS | Receiver start enables, identical copies |
| clk_en | output | N_CLK | Clock start enables, identical copies |
| ro_go | output | 1 | One-cycle internal start-readout pulse for the readout sequencer |

## Verification
Two situations are the hardest to reach. The first is a request pulse that rises and falls between two clock edges. It must still be latched, it must start the receivers, and the clocks must never start. The bench reaches it by moving `daq_on` at fractions of a cycle after the falling edge and sampling before the next rising edge. The second is a readout request that arrives while the acquisition request already has the clocks running. This case needs `ro_go` without any synchronizer delay, and a second readout after `ro_done` must fire `ro_go` once more. The directed sequence holds `daq_on` high across both readouts to reach it.

// File: rtl/pg_pkg.sv
`timescale 1ns/1ps
package pg_pkg;
  // Index of each request source in the latched request vector.
  localparam int REQ_DAQ = 0;
  localparam int REQ_RO  = 1;
  localparam int NUM_REQ = 2;

  typedef logic [NUM_REQ-1:0] req_vec_t;
endpackage

// File: rtl/pg_req_latch.sv
`timescale 1ns/1ps
// Request flop: asynchronous set, synchronous clear on the slow clock.
module pg_req_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or posedge set_i) begin
    if (set_i)
      q_o <= 1'b1;
    else if (rst || clr_i)
      q_o <= 1'b0;
  end

  // R7: a latched request stays latched until a clear is seen at an edge
  a_r7_hold_until_clear: assert property (@(posedge clk) disable iff (rst)
    (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/pg_enable_sync.sv
`timescale 1ns/1ps
// Builds the receiver and clock enables from the internal power-on.
// Receiver enables start asynchronously. Clock enables start through a
// synchronizer chain. Both are cleared on the same edge when power-on is low.
module pg_enable_sync #(
  parameter int N_LVDS      = 2,
  parameter int N_CLK       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              on_i,
  input  logic              arm_i,
  output logic [N_LVDS-1:0] lvds_en_o,
  output logic [N_CLK-1:0]  clk_en_o
);
  localparam int CHAIN = (SYNC_STAGES > 1) ? SYNC_STAGES - 1 : 1;

  logic chain_q [CHAIN];

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst || !on_i)
            chain_q[0] <= 1'b0;
          else
            chain_q[0] <= 1'b1;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst || !on_i)
            chain_q[i] <= 1'b0;
          else
            chain_q[i] <= chain_q[i-1];
        end
      end
    end

    // Last synchronizer stage, one copy per clock enable output.
    for (genvar k = 0; k < N_CLK; k++) begin : g_clk_copy
      logic en_q;
      always_ff @(posedge clk) begin
        if (rst || !on_i)
          en_q <= 1'b0;
        else
          en_q <= chain_q[CHAIN-1];
      end
      assign clk_en_o[k] = en_q;
    end

    // Receiver enables: set at once by a raw request, cleared with the clocks.
    for (genvar k = 0; k < N_LVDS; k++) begin : g_lvds_copy
      logic en_q;
      always_ff @(posedge clk or posedge arm_i) begin
        if (arm_i)
          en_q <= 1'b1;
        else if (rst || !on_i)
          en_q <= 1'b0;
      end
      assign lvds_en_o[k] = en_q;
    end
  endgenerate

  // R5: power-on low at an edge leaves every clock enable low after it
  a_r5_clk_off_after_release: assert property (@(posedge clk) disable iff (rst)
    !on_i |=> (clk_en_o == '0));

  // R3: a clock enable only rises after power-on was held for two edges
  a_r3_clk_start_latency: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_en_o[0]) |-> (on_i && $past(on_i)));
endmodule

// File: rtl/pg_ro_launch.sv
`timescale 1ns/1ps
// Issues a one-cycle start pulse per readout request once clocks are running.
module pg_ro_launch (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic clk_on_i,
  output logic go_o
);
  logic issued_q;

  always_ff @(posedge clk) begin
    if (rst || !req_i) begin
      go_o     <= 1'b0;
      issued_q <= 1'b0;
    end else begin
      go_o <= clk_on_i && !issued_q;
      if (clk_on_i)
        issued_q <= 1'b1;
    end
  end

  // R9: the launch pulse lasts a single cycle
  a_r9_single_cycle: assert property (@(posedge clk) disable iff (rst)
    go_o |=> !go_o);

  // R9: the launch pulse only appears while the clocks are enabled
  a_r9_needs_clock: assert property (@(posedge clk) disable iff (rst)
    go_o |-> clk_on_i);
endmodule

// File: rtl/dig_power_gate.sv
`timescale 1ns/1ps
module dig_power_gate
  import pg_pkg::*;
#(
  parameter int N_LVDS      = 2,
  parameter int N_CLK       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              daq_on,
  input  logic              ro_start,
  input  logic              ro_done,
  output logic              pwr_on,
  output logic [N_LVDS-1:0] lvds_en,
  output logic [N_CLK-1:0]  clk_en,
  output logic              ro_go
);
  req_vec_t req_q;
  logic     arm;

  // Acquisition request: released when the input drops.
  pg_req_latch u_daq_req (
    .clk   (clk),
    .rst   (rst),
    .set_i (daq_on),
    .clr_i (!daq_on),
    .q_o   (req_q[REQ_DAQ])
  );

  // Readout request: set by the chain pulse, released at end of readout.
  pg_req_latch u_ro_req (
    .clk   (clk),
    .rst   (rst),
    .set_i (ro_start),
    .clr_i (ro_done),
    .q_o   (req_q[REQ_RO])
  );

  assign pwr_on = |req_q;
  assign arm    = daq_on | ro_start;

  pg_enable_sync #(
    .N_LVDS      (N_LVDS),
    .N_CLK       (N_CLK),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_en (
    .clk       (clk),
    .rst       (rst),
    .on_i      (pwr_on),
    .arm_i     (arm),
    .lvds_en_o (lvds_en),
    .clk_en_o  (clk_en)
  );

  pg_ro_launch u_launch (
    .clk      (clk),
    .rst      (rst),
    .req_i    (req_q[REQ_RO]),
    .clk_on_i (clk_en[0]),
    .go_o     (ro_go)
  );

  // R6: copies move together and clocks never run without receivers
  a_r6_lockstep: assert property (@(posedge clk) disable iff (rst)
    (clk_en != '0) |-> (clk_en == '1 && lvds_en == '1));

  // R4: a held acquisition input keeps power-on high
  a_r4_daq_keeps_power: assert property (@(posedge clk) disable iff (rst)
    daq_on |=> pwr_on);
endmodule

// File: tb/sim_dig_power_gate.sv
`timescale 1ns/1ps
module sim_dig_power_gate;
  localparam int N_LVDS = 2;
  localparam int N_CLK  = 2;
  localparam int NROWS  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic daq_on = 1'b0, ro_start = 1'b0, ro_done = 1'b0;
  logic pwr_on, ro_go;
  logic [N_LVDS-1:0] lvds_en;
  logic [N_CLK-1:0]  clk_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dig_power_gate #(.N_LVDS(N_LVDS), .N_CLK(N_CLK), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .daq_on(daq_on), .ro_start(ro_start),
    .ro_done(ro_done), .pwr_on(pwr_on), .lvds_en(lvds_en),
    .clk_en(clk_en), .ro_go(ro_go)
  );

  // Row: {daq_on, ro_start, ro_done | exp pwr_on, exp lvds all, exp clk all, exp ro_go}
  // Inputs are driven on a falling edge and checked 1 ns later.
  localparam logic [6:0] VEC [NROWS] = '{
    7'b000_0000, // 0  R1 idle after reset
    7'b100_1100, // 1  R2 receivers on before any edge
    7'b100_1100, // 2  R3 one edge: clocks still off
    7'b100_1110, // 3  R3 second edge: clocks on
    7'b110_1110, // 4  R7 readout pulse with clocks running
    7'b100_1111, // 5  R10 launch after first edge
    7'b100_1110, // 6  R9 single-cycle pulse
    7'b101_1110, // 7  R8 done applied
    7'b100_1110, // 8  R8 acquisition keeps power
    7'b000_1110, // 9  R5 release input, not yet seen
    7'b000_0110, // 10 R5 E0: pwr_on low, enables hold
    7'b000_0000, // 11 R5 E1: all enables low together
    7'b010_1100, // 12 R7 readout request alone
    7'b000_1100, // 13 R7 held after pulse
    7'b000_1110, // 14 R3 clocks on
    7'b000_1111, // 15 R9 launch one edge after clocks
    7'b000_1110, // 16 R9 pulse ended
    7'b001_1110, // 17 R8 done applied
    7'b000_0110, // 18 R4 no request: pwr_on low
    7'b000_0000  // 19 R5 all off
  };
  localparam int TAG [NROWS] = '{1,2,3,3,7,10,9,8,8,5,5,5,7,7,3,9,9,8,4,5};

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic p, input logic l,
                         input logic c, input logic g);
    chk(req, "pwr_on", int'(pwr_on), int'(p));
    chk(req, "lvds_en", int'(lvds_en), l ? ((1 << N_LVDS) - 1) : 0);
    chk(req, "clk_en", int'(clk_en), c ? ((1 << N_CLK) - 1) : 0);
    chk(req, "ro_go", int'(ro_go), int'(g));
  endtask

  task automatic step(input logic d, input logic s, input logic e);
    @(negedge clk);
    daq_on = d; ro_start = s; ro_done = e;
    #1;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    chk_all("R1", 1'b0, 1'b0, 1'b0, 1'b0); // R1 reset state
    @(negedge clk);
    rst = 1'b0;

    // Table walk
    for (int r = 0; r < NROWS; r++) begin
      step(VEC[r][6], VEC[r][5], VEC[r][4]);
      chk_all($sformatf("R%0d", TAG[r]), VEC[r][3], VEC[r][2], VEC[r][1], VEC[r][0]);
    end

    // R2: short acquisition pulse between two edges is latched, clocks never start
    step(1'b1, 1'b0, 1'b0);
    chk_all("R2", 1'b1, 1'b1, 1'b0, 1'b0);
    #0.5 daq_on = 1'b0;
    #0.5 chk_all("R2", 1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R5", 1'b0, 1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R5", 1'b0, 1'b0, 1'b0, 1'b0);

    // R11: reset in the middle of a readout
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R11", 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R11", 1'b0, 1'b0, 1'b0, 1'b0);

    // R10: two readouts while acquisition keeps the clocks running
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R3", 1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R10", 1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R10", 1'b1, 1'b1, 1'b1, 1'b0); // once per request
    step(1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R8", 1'b1, 1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk_all("R10", 1'b1, 1'b1, 1'b1, 1'b1); // second readout fires again
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R5", 1'b0, 1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk_all("R6", 1'b0, 1'b0, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule